// File: doc/BRIEF.md
# Burst-Framed SPI Register Master

This block is an SPI master for a network controller whose register access uses a variable-length frame. A host issues one command. The command carries a 16-bit register offset, a 5-bit block code, a direction flag and a byte count. The block then runs the whole access under a single chip-select period. It first shifts out a 24-bit header, made of the offset followed by a control byte. It then moves the requested number of data bytes, MSB first. Finally it releases the bus.

Write data is taken from a ready/valid input stream. Read data is handed out on a ready/valid output stream. If the write stream is empty, or the read stream is not accepted, the frame pauses with the serial clock parked high. The frame is not ended in that case. Two kinds of delay keep slow or noisy links reliable. The first is the serial clock phase length, which is set by a run-time divider register. Its reset default is deliberately slow. The second is a fixed settling delay, inserted around every chip-select change.

Top module: `spi_burst_master`

## Requirements
- R1: After reset and between frames, the block holds its serial outputs at rest: chip select high, clock high and data-out low. It also shows cmd_ready high and busy low.
- R2: The frame header is 24 bits, sent MSB first. The 16-bit offset comes first. The control byte follows it: block code in bits [7:3], direction in bit [2] (1 = write, 0 = read), and mode bits [1:0] = 00.
- R3: A single chip-select low period covers the header and exactly cmd_len data bytes. A count of zero sends the header alone.
- R4: Data-out changes only when the serial clock falls, and it stays fixed while the clock is high. Write bytes reach the device MSB first. Read bits are taken at the end of each high phase, and the first bit taken becomes bit 7.
- R5: Every serial clock low phase lasts exactly D system clocks, where D is the divider register value; a value of 0 acts as 1. The divider resets to HALF_RST, which defaults to 1000.
- R6: After chip select falls, the clock stays high for exactly SETTLE system clocks before its first fall. The block also waits SETTLE clocks before raising chip select and SETTLE clocks after raising it.
- R7: At the end of a frame, chip select rises only while the clock is high, and data-out is returned low.
- R8: Each read byte is presented on rd_data with rd_valid. It is held unchanged until rd_ready. No further clock edge occurs until the byte is taken.
- R9: A command is accepted only when cmd_ready is high, which is only when the block is idle. busy stays high from acceptance until the settling time after chip-select release has ended.
- R10: In a write frame with no input byte available, wr_ready is high, chip select stays low and the clock stays high, for as long as the stall lasts.
- R11: A divider write made while busy is ignored. A write made while idle applies to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Divider register write strobe |
| cfg_half | input | DIV_W | New clock phase length in system clocks |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted (idle) |
| cmd_offset | input | 16 | Register offset for the header |
| cmd_block | input | 5 | Block code for the control byte |
| cmd_write | input | 1 | 1 = write frame, 0 = read frame |
| cmd_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Frame in progress |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Block waiting for a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench keeps HALF_RST at 1000, so the first frame checks the slow reset rate at full length. It builds SETTLE at 3, so the exact settle count can be measured, and it uses DIV_W 16. After that first frame it reprograms the divider to 2, 0 (which acts as 1) and 3. These short phases make it affordable to run a few dozen randomized read and write frames. The frames use stalled input streams and a throttled output stream, against a device model with a register array. A directed frame writes 192, 168, 1, 228 at offset 0x000F in block 0 and reads them back. Another frame is held stalled long enough to test the divider freeze.

// File: rtl/spi_burst_pkg.sv
// Shared types and helpers for the burst-framed SPI master.
// Assumes a 16-bit offset and an 8-bit control byte (24-bit header).
package spi_burst_pkg;

    // Controller states, in frame order.
    typedef enum logic [2:0] {
        ST_IDLE,     // bus at rest, command accepted here
        ST_CS_ON,    // chip select low, settling before first edge
        ST_BIT_LO,   // clock low phase of one bit
        ST_BIT_HI,   // clock high phase of one bit
        ST_FETCH,    // waiting for a write byte, clock parked high
        ST_PUSH,     // offering a read byte, clock parked high
        ST_TAIL,     // settling before chip select rises
        ST_RELEASE   // settling after chip select rose
    } sb_state_e;

    localparam int          HDR_BITS = 24;
    localparam logic [1:0]  MODE_VAR = 2'b00;

    // Control byte: block code on top, direction, then mode bits.
    function automatic logic [7:0] sb_ctrl_byte(input logic [4:0] blk, input logic wr);
        return {blk, wr, MODE_VAR};
    endfunction

endpackage

// File: rtl/spi_burst_timer.sv
// Down-counter used for every timed phase of the frame.
// Assumes the caller loads (length - 1); expired is high while the count is zero.
module spi_burst_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load a new length or count one step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5: the phase counter moves by exactly one per clock when not reloaded.
    p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/spi_burst_halfreg.sv
// Holds the clock phase length and turns it into a timer load value.
// Assumes writes are only honoured while the frame engine is idle.
module spi_burst_halfreg #(
    parameter int W   = 16,
    parameter int RST = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         busy,
    input  logic         cfg_we,
    input  logic [W-1:0] cfg_half,
    output logic [W-1:0] phase_ld
);
    logic [W-1:0] half_q;

    // Capture a new phase length only between frames.
    always_ff @(posedge clk) begin
        if (!rst_n)                half_q <= W'(RST);
        else if (cfg_we && !busy)  half_q <= cfg_half;
    end

    // A zero setting behaves as a one-cycle phase.
    assign phase_ld = (half_q == '0) ? '0 : half_q - 1'b1;

    // R11: the phase length cannot move while a frame is running.
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(half_q));

endmodule

// File: rtl/spi_burst_rxbyte.sv
// Serial-to-parallel assembler for read bytes, first bit ends up in bit 7.
// Assumes sample is pulsed once per bit, at the end of the clock high phase.
module spi_burst_rxbyte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       bit_in,
    output logic [7:0] next_byte
);
    logic [7:0] acc_q;

    assign next_byte = {acc_q[6:0], bit_in};

    // Shift in one received bit per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (sample) acc_q <= next_byte;
    end

endmodule

// File: rtl/spi_burst_master.sv
// Burst-framed SPI master: one chip-select period carries a 24-bit header
// (offset, then control byte) followed by cmd_len data bytes, MSB first.
// Assumes the device samples on the rising clock edge and changes its output
// on the falling edge; clock idles high. All serial outputs are registered.
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int HALF_RST = 1000,
    parameter int SETTLE   = 4,
    parameter int LEN_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [15:0]      cmd_offset,
    input  logic [4:0]       cmd_block,
    input  logic             cmd_write,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             busy,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam logic [DIV_W-1:0] SETTLE_LD = DIV_W'(SETTLE - 1);
    localparam logic [4:0]       HDR_LAST  = 5'(HDR_BITS - 1);

    sb_state_e          state_q, state_n;
    logic [23:0]        sh_q, sh_n;
    logic [4:0]         bit_q, bit_n;
    logic [LEN_W-1:0]   left_q, left_n;
    logic               hdr_q, hdr_n;
    logic               wr_q, wr_n;
    logic               mosi_q, mosi_n;
    logic [7:0]         rd_q, rd_n;
    logic               cs_q, sclk_q;
    logic               t_load, t_exp, sample;
    logic [DIV_W-1:0]   t_val, phase_ld;
    logic [7:0]         rx_next;

    spi_burst_timer #(.W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    spi_burst_halfreg #(.W(DIV_W), .RST(HALF_RST)) u_half (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_we(cfg_we),
        .cfg_half(cfg_half), .phase_ld(phase_ld)
    );

    spi_burst_rxbyte u_rx (
        .clk(clk), .rst_n(rst_n), .sample(sample), .bit_in(spi_miso), .next_byte(rx_next)
    );

    // Frame sequencing: next state, shift data, counters and timer loads.
    always_comb begin
        state_n = state_q;  sh_n = sh_q;   bit_n = bit_q;  left_n = left_q;
        hdr_n   = hdr_q;    wr_n = wr_q;   mosi_n = mosi_q; rd_n = rd_q;
        t_load  = 1'b0;     t_val = phase_ld;  sample = 1'b0;
        case (state_q)
            ST_IDLE: if (cmd_valid) begin
                state_n = ST_CS_ON;  t_load = 1'b1;  t_val = SETTLE_LD;
                sh_n    = {cmd_offset, sb_ctrl_byte(cmd_block, cmd_write)};
                bit_n   = HDR_LAST;  left_n = cmd_len;  hdr_n = 1'b1;  wr_n = cmd_write;
            end
            ST_CS_ON: if (t_exp) begin
                state_n = ST_BIT_LO;  t_load = 1'b1;  mosi_n = sh_q[23];
            end
            ST_BIT_LO: if (t_exp) begin
                state_n = ST_BIT_HI;  t_load = 1'b1;
            end
            ST_BIT_HI: if (t_exp) begin
                sample = !hdr_q && !wr_q;
                if (bit_q != '0) begin
                    bit_n   = bit_q - 1'b1;  sh_n = {sh_q[22:0], 1'b0};
                    state_n = ST_BIT_LO;     t_load = 1'b1;
                    mosi_n  = (hdr_q || wr_q) ? sh_q[22] : 1'b0;
                end else if (!hdr_q && !wr_q) begin
                    state_n = ST_PUSH;  rd_n = rx_next;
                end else if (left_q == '0) begin
                    state_n = ST_TAIL;  t_load = 1'b1;  t_val = SETTLE_LD;
                end else if (wr_q) begin
                    state_n = ST_FETCH;  hdr_n = 1'b0;
                end else begin
                    hdr_n   = 1'b0;  left_n = left_q - 1'b1;  bit_n = 5'd7;
                    state_n = ST_BIT_LO;  t_load = 1'b1;  mosi_n = 1'b0;
                end
            end
            ST_FETCH: if (wr_valid) begin
                sh_n    = {wr_data, 16'h0000};  left_n = left_q - 1'b1;  bit_n = 5'd7;
                state_n = ST_BIT_LO;  t_load = 1'b1;  mosi_n = wr_data[7];
            end
            ST_PUSH: if (rd_ready) begin
                if (left_q == '0) begin
                    state_n = ST_TAIL;  t_load = 1'b1;  t_val = SETTLE_LD;
                end else begin
                    left_n  = left_q - 1'b1;  bit_n = 5'd7;
                    state_n = ST_BIT_LO;  t_load = 1'b1;  mosi_n = 1'b0;
                end
            end
            ST_TAIL: if (t_exp) begin
                state_n = ST_RELEASE;  t_load = 1'b1;  t_val = SETTLE_LD;  mosi_n = 1'b0;
            end
            ST_RELEASE: if (t_exp) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // State, datapath and registered pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  sh_q <= '0;  bit_q <= '0;  left_q <= '0;
            hdr_q   <= 1'b0;  wr_q <= 1'b0;  mosi_q <= 1'b0;  rd_q <= '0;
            cs_q    <= 1'b1;  sclk_q <= 1'b1;
        end else begin
            state_q <= state_n;  sh_q <= sh_n;  bit_q <= bit_n;  left_q <= left_n;
            hdr_q   <= hdr_n;  wr_q <= wr_n;  mosi_q <= mosi_n;  rd_q <= rd_n;
            cs_q    <= (state_n == ST_IDLE) || (state_n == ST_RELEASE);
            sclk_q  <= (state_n != ST_BIT_LO);
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign busy      = !cmd_ready;
    assign wr_ready  = (state_q == ST_FETCH);
    assign rd_valid  = (state_q == ST_PUSH);
    assign rd_data   = rd_q;
    assign spi_cs_n  = cs_q;
    assign spi_sclk  = sclk_q;
    assign spi_mosi  = mosi_q;

    // R1: at rest all three serial lines sit at their idle levels.
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (spi_cs_n && spi_sclk && !spi_mosi));

    // R4: data-out never moves during a clock high phase inside a frame.
    p_mosi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && spi_sclk && $past(spi_sclk) && !$past(spi_cs_n)) |-> $stable(spi_mosi));

    // R6: chip select falls with the clock already parked high.
    p_cs_fall_clk_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> spi_sclk);

    // R7: chip select rises only with the clock high and data-out low.
    p_cs_rise_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (spi_sclk && !spi_mosi));

    // R8: an offered read byte is held until taken.
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R8: no clock edge while a read byte waits.
    p_rd_clk_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> spi_sclk);

    // R9: an accepted command makes the block busy and closes the command port.
    p_cmd_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

    // R10: a write stall keeps the frame open with the clock high.
    p_stall_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (spi_sclk && !spi_cs_n));

endmodule

// File: tb/sim_spi_burst_master.sv
`timescale 1ns/1ps
module sim_spi_burst_master;
    localparam int DIV_W  = 16;
    localparam int SETTLE = 3;
    localparam int LEN_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [DIV_W-1:0] cfg_half = '0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [15:0] cmd_offset = '0;
    logic [4:0] cmd_block = '0;
    logic cmd_write = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic busy;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [7:0] wr_data = '0;
    logic rd_valid;
    logic rd_ready = 1'b0;
    logic [7:0] rd_data;
    logic spi_cs_n, spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;

    int tests = 0;
    int fails = 0;
    int exp_half = 1000;

    always #2.5 clk = ~clk;

    spi_burst_master #(.DIV_W(DIV_W), .HALF_RST(1000), .SETTLE(SETTLE), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_half(cfg_half),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_offset(cmd_offset),
        .cmd_block(cmd_block), .cmd_write(cmd_write), .cmd_len(cmd_len), .busy(busy),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Device model: register array addressed by block code and low six offset bits.
    logic [7:0] smem [0:2047];
    logic [7:0] mmem [0:2047];
    logic [23:0] s_hdr = '0;
    logic [7:0]  s_db = '0;
    int s_bits = 0;
    int s_last_bits = -1;

    function automatic int sidx(input logic [23:0] h, input int k);
        return int'(h[7:3]) * 64 + ((int'(h[23:8]) + k) % 64);
    endfunction

    always @(posedge spi_cs_n or posedge spi_sclk) begin
        if (spi_cs_n) begin
            if (s_bits > 0) s_last_bits = s_bits;
            s_bits = 0;
        end else begin
            if (s_bits < 24) s_hdr = {s_hdr[22:0], spi_mosi};
            else if (s_hdr[2]) begin
                s_db = {s_db[6:0], spi_mosi};
                if (((s_bits - 24) % 8) == 7) smem[sidx(s_hdr, (s_bits - 24) / 8)] = s_db;
            end
            s_bits++;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && s_bits >= 24 && !s_hdr[2])
            spi_miso = smem[sidx(s_hdr, (s_bits - 24) / 8)][7 - ((s_bits - 24) % 8)];
    end

    // R5: every clock low phase lasts exactly the programmed length.
    int lowcnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_sclk) lowcnt++;
            else if (lowcnt != 0) begin
                chk(lowcnt == exp_half, "R5 low phase length", lowcnt, exp_half);
                lowcnt = 0;
            end
        end
    end

    // R6: clock stays high exactly SETTLE cycles after chip select falls.
    logic prev_cs = 1'b1;
    bit in_settle = 1'b0;
    int settle_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n && prev_cs) begin in_settle = 1'b1; settle_cnt = 0; end
            if (in_settle) begin
                if (spi_sclk) settle_cnt++;
                else begin
                    chk(settle_cnt == SETTLE, "R6 settle before first edge", settle_cnt, SETTLE);
                    in_settle = 1'b0;
                end
            end
        end
        prev_cs = spi_cs_n;
    end

    task automatic set_half(input int v);
        cfg_half = DIV_W'(v); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic [15:0] off, input logic [4:0] blk, input bit w, input int n);
        s_last_bits = -1;
        cmd_offset = off; cmd_block = blk; cmd_write = w; cmd_len = LEN_W'(n);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        wr_valid = 1'b1; wr_data = b;
        forever begin
            if (wr_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic finish_frame(input logic [15:0] off, input logic [4:0] blk, input bit w, input int n);
        logic [23:0] eh;
        while (busy) @(negedge clk);
        eh = {off, blk, w, 2'b00};
        chk(s_hdr == eh, "R2 header bits", int'(s_hdr), int'(eh));
        chk(s_last_bits == 24 + 8 * n, "R3 bits under one chip select", s_last_bits, 24 + 8 * n);
        chk(spi_cs_n && spi_sclk && !spi_mosi, "R7 lines at frame end",
            int'({spi_cs_n, spi_sclk, spi_mosi}), 6);
        if (w) for (int k = 0; k < n; k++)
            chk(smem[sidx(eh, k)] == mmem[sidx(eh, k)], "R4 write byte MSB first",
                int'(smem[sidx(eh, k)]), int'(mmem[sidx(eh, k)]));
    endtask

    task automatic write_frame(input logic [15:0] off, input logic [4:0] blk, input int n,
                               input logic [7:0] d [8], input bit gaps);
        issue(off, blk, 1'b1, n);
        for (int k = 0; k < n; k++) begin
            mmem[sidx({off, blk, 3'b100}, k)] = d[k];
            send_byte(d[k], gaps ? int'($urandom % 5) : 0);
        end
        finish_frame(off, blk, 1'b1, n);
    endtask

    task automatic read_frame(input logic [15:0] off, input logic [4:0] blk, input int n, input bit throttle);
        int got;
        logic [7:0] e;
        issue(off, blk, 1'b0, n);
        got = 0;
        while (got < n) begin
            rd_ready = throttle ? ($urandom % 3 != 0) : 1'b1;
            if (rd_valid && rd_ready) begin
                e = mmem[sidx({off, blk, 3'b000}, got)];
                chk(rd_data == e, "R8 read byte", int'(rd_data), int'(e));
                got++;
            end
            @(negedge clk);
        end
        rd_ready = 1'b0;
        finish_frame(off, blk, 1'b0, n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d [8];
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 2048; i++) begin
            smem[i] = 8'(i * 7 + 3);
            mmem[i] = 8'(i * 7 + 3);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: rest levels after reset.
        chk(spi_cs_n && spi_sclk && !spi_mosi, "R1 idle lines",
            int'({spi_cs_n, spi_sclk, spi_mosi}), 6);
        chk(cmd_ready && !busy, "R1 idle handshake", int'({cmd_ready, busy}), 2);

        // R5: reset default phase length, header-only frame (R3 with zero count).
        exp_half = 1000;
        for (int k = 0; k < 8; k++) d[k] = 8'h00;
        write_frame(16'h1234, 5'd3, 0, d, 1'b0);

        set_half(2); exp_half = 2;
        // Directed address write and readback at offset 0x000F, block 0.
        d[0] = 8'd192; d[1] = 8'd168; d[2] = 8'd1; d[3] = 8'd228;
        write_frame(16'h000F, 5'd0, 4, d, 1'b0);
        read_frame(16'h000F, 5'd0, 4, 1'b0);

        // R10, R9, R11: stalled write frame with a divider write attempt.
        issue(16'h0020, 5'd7, 1'b1, 2);
        repeat (150) @(negedge clk);
        chk(wr_ready && !spi_cs_n && spi_sclk, "R10 stall keeps frame open",
            int'({wr_ready, spi_cs_n, spi_sclk}), 5);
        chk(busy && !cmd_ready, "R9 busy during frame", int'({busy, cmd_ready}), 2);
        set_half(5);
        repeat (20) @(negedge clk);
        chk(spi_sclk && !spi_cs_n, "R10 still parked", int'({spi_sclk, spi_cs_n}), 2);
        d[0] = 8'hA5; d[1] = 8'h3C;
        for (int k = 0; k < 2; k++) begin
            mmem[sidx({16'h0020, 5'd7, 3'b100}, k)] = d[k];
            send_byte(d[k], 0);
        end
        finish_frame(16'h0020, 5'd7, 1'b1, 2);
        // R11: low phases of the frame above were checked against 2; confirm again.
        read_frame(16'h0020, 5'd7, 2, 1'b0);

        // R5, R11: zero acts as one; idle write takes effect.
        set_half(0); exp_half = 1;
        for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
        write_frame(16'h0031, 5'd12, 3, d, 1'b1);
        read_frame(16'h0031, 5'd12, 3, 1'b1);

        set_half(3); exp_half = 3;
        for (int t = 0; t < 24; t++) begin
            logic [15:0] off;
            logic [4:0] blk;
            int n;
            off = 16'($urandom);
            blk = 5'($urandom);
            n = int'($urandom % 6);
            if ($urandom % 2 == 0) begin
                for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
                write_frame(off, blk, n, d, 1'b1);
            end else begin
                read_frame(off, blk, n, 1'b1);
            end
        end
        chk(cmd_ready && !busy && spi_cs_n && spi_sclk && !spi_mosi, "R1 rest after run",
            int'({cmd_ready, busy, spi_cs_n, spi_sclk, spi_mosi}), 22);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule